// File: doc/BRIEF.md
# DMA Command Token Decoder

This block sits between a command issuer and a two-port DMA engine with 32 channels. It accepts a stream of 32-bit tokens on a valid/ready input and parses variable-length command sequences. Configuration sequences update a per-channel register file. That file holds the connection, the extension mode and the height, and for each of port A and port B a stride, an element count, a left crop and a width. Transfer sequences produce one decoded request. The request carries the channel, the direction, the clear flag, the acknowledge flag, the fast-transfer fields and the operand words. The stored configuration of the addressed channel is presented alongside it.

The first token of every sequence holds a 6-bit command id in bits 5:0 and a channel number in bits 10:6. A config-class id (bit 5 set) with bit 0 set is a single-parameter update, which also carries a 4-bit parameter id in bits 14:11. The id 0x20 starts a full configuration. The id 0x22 arms a transfer. Any other config-class id is unknown.

The control is a state machine with these states:
- S_IDLE waits for a first token.
- S_CFG counts eight configuration words.
- S_PARAM takes one value word.
- S_XCMD takes the transfer command token.
- S_DST, S_SRC, S_DVAR and S_SVAR take the operand words.
- S_ISSUE holds the request until it is accepted.

The transitions are:
- S_IDLE goes to S_CFG on 0x20, to S_PARAM on a parameter token, and to S_XCMD on 0x22. It stays in S_IDLE, flagging an error, on anything else.
- S_CFG goes to S_IDLE after its eighth word.
- S_PARAM goes to S_IDLE after one word.
- S_XCMD goes to S_DST on a transfer-class id (bit 5 clear). Otherwise it goes back to S_IDLE with an error.
- S_DST goes to S_SRC, and S_SRC goes to S_DVAR.
- S_DVAR goes to S_ISSUE when the clear bit is set, and to S_SVAR otherwise.
- S_SVAR goes to S_ISSUE.
- S_ISSUE goes to S_IDLE when the request is accepted.

Top module: `dma_token_decoder`

## Requirements
- R1: After reset, tok_ready is 1 and req_valid, ack_pulse and err_pulse are 0. Every configuration field of every channel reads as zero.
- R2: A full configuration is the token with id 0x20 followed by eight words. Those words are, in order: setup, stride A, elems/crop A, width A, stride B, elems/crop B, width B and height. Setup carries the connection in bits 1:0 and the sign-extension flag in bit 8. Each elems/crop word carries the element count in bits 7:0 and the left crop in bits 15:8. Widths take bits 15:0, height takes bits 7:0, and strides take all 32 bits.
- R3: A parameter token (id with bits 5 and 0 set) with parameter id 0..7 is followed by one value word. That word updates only the selected field of that channel. The ids map to fields as follows: 0 setup, 1 height, 2 stride A, 3 elems/crop A, 4 width A, 5 stride B, 6 elems/crop B, 7 width B.
- R4: A parameter id of 8..15 still consumes its value word but changes no field. err_pulse is high for the one cycle after the parameter token is accepted.
- R5: A transfer is the token 0x22, then a command token with bit 5 clear, then a destination word, a source word and a destination-variable word. req_valid rises in the cycle after the last word is accepted. The request carries the channel from bits 10:6 of the command token, the three words, and the channel's stored configuration.
- R6: When the clear bit (id bit 3) is set, the sequence ends after the destination-variable word and req_src_var is 0. Otherwise a source-variable word follows and appears on req_src_var.
- R7: req_a2b equals id bit 2 and req_clear equals id bit 3. req_ack_needed is 1 exactly when id bits 4 and 1 are both 0.
- R8: req_fast equals id bit 0. The fast fields come from the command token: height from bits 31:26, the upper width from bits 25:18 and the lower width from bits 17:11.
- R9: While req_valid is high and req_ready is low, tok_ready is 0, and req_valid and all request fields hold their values.
- R10: ack_pulse is high only in the cycle when req_valid and req_ready are both high for a request whose acknowledge flag is set. The cycle after acceptance has no request.
- R11: An unknown config-class id, a transfer-class id with no preceding 0x22 token, or a non-transfer id in place of the command token is dropped. err_pulse is high for one cycle after such a token is accepted, and the decoder returns to S_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token offered |
| tok_data | input | 32 | Token word |
| tok_ready | output | 1 | Token accepted when high with tok_valid |
| req_valid | output | 1 | Decoded transfer request present |
| req_ready | input | 1 | Downstream accepts the request |
| req_channel | output | 5 | Channel of the transfer |
| req_a2b | output | 1 | 1: port A to port B, 0: port B to port A |
| req_clear | output | 1 | Clear (fill) transfer |
| req_ack_needed | output | 1 | Acknowledge required |
| req_fast | output | 1 | Fast transfer |
| req_fast_height | output | 6 | Fast-transfer height |
| req_fast_w_hi | output | 8 | Fast-transfer upper width field |
| req_fast_w_lo | output | 7 | Fast-transfer lower width field |
| req_dst_addr | output | 32 | Destination address word |
| req_src_word | output | 32 | Source address or fill value |
| req_dst_var | output | 32 | Destination-variable flag word |
| req_src_var | output | 32 | Source-variable flag word (0 for clear) |
| req_conn | output | 2 | Stored connection of the channel |
| req_sign_ext | output | 1 | Stored extension mode (1 = sign) |
| req_height | output | 8 | Stored height |
| req_stride_a | output | 32 | Stored stride, port A |
| req_elems_a | output | 8 | Stored element count, port A |
| req_crop_a | output | 8 | Stored left crop, port A |
| req_width_a | output | 16 | Stored width, port A |
| req_stride_b | output | 32 | Stored stride, port B |
| req_elems_b | output | 8 | Stored element count, port B |
| req_crop_b | output | 8 | Stored left crop, port B |
| req_width_b | output | 16 | Stored width, port B |
| ack_pulse | output | 1 | Acknowledge strobe on acceptance |
| err_pulse | output | 1 | Dropped or ignored token strobe |

## Verification
The request fields and req_valid are due one clock edge after the handshake of a sequence's last word. Each bench task returns on the falling edge that follows that handshake and samples the request there. err_pulse is registered in the same way, so it is sampled on that same falling edge and again one cycle later, when it must be low. ack_pulse is combinational from req_ready, so the bench raises req_ready on a falling edge and reads ack_pulse a moment later, before the accepting edge. Configuration writes are checked through the stored fields that a later transfer on the same channel presents.

// File: rtl/dmatok_pkg.sv
package dmatok_pkg;
    localparam int TOK_W     = 32;
    localparam int CMD_W     = 6;
    localparam int CH_LSB    = 6;
    localparam int PID_LSB   = 11;
    localparam int PID_W     = 4;
    localparam int CONN_W    = 2;
    localparam int SEXT_BIT  = 8;
    localparam int ELEM_W    = 8;
    localparam int CROP_LSB  = 8;
    localparam int HEIGHT_W  = 8;
    localparam int WIDTH_W   = 16;
    localparam int STRIDE_W  = 32;
    localparam int FH_LSB    = 26;
    localparam int FH_W      = 6;
    localparam int FWH_LSB   = 18;
    localparam int FWH_W     = 8;
    localparam int FWL_LSB   = 11;
    localparam int FWL_W     = 7;
    localparam int CFG_WORDS = 8;

    localparam logic [CMD_W-1:0] ID_FULL_CFG = 6'h20;
    localparam logic [CMD_W-1:0] ID_ARM      = 6'h22;

    typedef enum logic [2:0] {
        K_FULL_CFG, K_PARAM, K_ARM, K_XFER, K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        F_SETUP    = 3'd0,
        F_HEIGHT   = 3'd1,
        F_STRIDE_A = 3'd2,
        F_CE_A     = 3'd3,
        F_WIDTH_A  = 3'd4,
        F_STRIDE_B = 3'd5,
        F_CE_B     = 3'd6,
        F_WIDTH_B  = 3'd7
    } field_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CFG, S_PARAM, S_XCMD, S_DST, S_SRC, S_DVAR, S_SVAR, S_ISSUE
    } state_e;

    typedef struct packed {
        logic [CONN_W-1:0]   conn;
        logic                sext;
        logic [HEIGHT_W-1:0] height;
        logic [STRIDE_W-1:0] stride_a;
        logic [ELEM_W-1:0]   elems_a;
        logic [ELEM_W-1:0]   crop_a;
        logic [WIDTH_W-1:0]  width_a;
        logic [STRIDE_W-1:0] stride_b;
        logic [ELEM_W-1:0]   elems_b;
        logic [ELEM_W-1:0]   crop_b;
        logic [WIDTH_W-1:0]  width_b;
    } chan_cfg_t;

    // Word position within a full configuration -> field written
    function automatic field_e seq_field(input logic [2:0] idx);
        case (idx)
            3'd0:    return F_SETUP;
            3'd1:    return F_STRIDE_A;
            3'd2:    return F_CE_A;
            3'd3:    return F_WIDTH_A;
            3'd4:    return F_STRIDE_B;
            3'd5:    return F_CE_B;
            3'd6:    return F_WIDTH_B;
            default: return F_HEIGHT;
        endcase
    endfunction
endpackage

// File: rtl/dmatok_cmd_classify.sv
module dmatok_cmd_classify
    import dmatok_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_id,
    output kind_e            kind,
    output logic             a2b,
    output logic             clear,
    output logic             ack_req,
    output logic             fast
);
    always_comb begin
        a2b     = cmd_id[2];
        clear   = cmd_id[3];
        ack_req = !(cmd_id[4] || cmd_id[1]);
        fast    = cmd_id[0];
        if (!cmd_id[5])
            kind = K_XFER;
        else if (cmd_id[0])
            kind = K_PARAM;
        else if (cmd_id == ID_FULL_CFG)
            kind = K_FULL_CFG;
        else if (cmd_id == ID_ARM)
            kind = K_ARM;
        else
            kind = K_BAD;
    end
endmodule

// File: rtl/dmatok_cfg_regs.sv
module dmatok_cfg_regs
    import dmatok_pkg::*;
#(
    parameter int N_CH = 32,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  field_e           wr_field,
    input  logic [TOK_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_ch,
    output chan_cfg_t        rd_cfg
);
    chan_cfg_t regs [N_CH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) regs[i] <= '0;
        end else if (wr_en) begin
            unique case (wr_field)
                F_SETUP: begin
                    regs[wr_ch].conn <= wr_data[CONN_W-1:0];
                    regs[wr_ch].sext <= wr_data[SEXT_BIT];
                end
                F_HEIGHT:   regs[wr_ch].height   <= wr_data[HEIGHT_W-1:0];
                F_STRIDE_A: regs[wr_ch].stride_a <= wr_data[STRIDE_W-1:0];
                F_CE_A: begin
                    regs[wr_ch].elems_a <= wr_data[ELEM_W-1:0];
                    regs[wr_ch].crop_a  <= wr_data[CROP_LSB +: ELEM_W];
                end
                F_WIDTH_A:  regs[wr_ch].width_a  <= wr_data[WIDTH_W-1:0];
                F_STRIDE_B: regs[wr_ch].stride_b <= wr_data[STRIDE_W-1:0];
                F_CE_B: begin
                    regs[wr_ch].elems_b <= wr_data[ELEM_W-1:0];
                    regs[wr_ch].crop_b  <= wr_data[CROP_LSB +: ELEM_W];
                end
                F_WIDTH_B:  regs[wr_ch].width_b  <= wr_data[WIDTH_W-1:0];
            endcase
        end
    end

    assign rd_cfg = regs[rd_ch];
endmodule

// File: rtl/dma_token_decoder.sv
module dma_token_decoder
    import dmatok_pkg::*;
#(
    parameter int N_CH = 32,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tok_valid,
    input  logic [TOK_W-1:0]    tok_data,
    output logic                tok_ready,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [CH_W-1:0]     req_channel,
    output logic                req_a2b,
    output logic                req_clear,
    output logic                req_ack_needed,
    output logic                req_fast,
    output logic [FH_W-1:0]     req_fast_height,
    output logic [FWH_W-1:0]    req_fast_w_hi,
    output logic [FWL_W-1:0]    req_fast_w_lo,
    output logic [TOK_W-1:0]    req_dst_addr,
    output logic [TOK_W-1:0]    req_src_word,
    output logic [TOK_W-1:0]    req_dst_var,
    output logic [TOK_W-1:0]    req_src_var,
    output logic [CONN_W-1:0]   req_conn,
    output logic                req_sign_ext,
    output logic [HEIGHT_W-1:0] req_height,
    output logic [STRIDE_W-1:0] req_stride_a,
    output logic [ELEM_W-1:0]   req_elems_a,
    output logic [ELEM_W-1:0]   req_crop_a,
    output logic [WIDTH_W-1:0]  req_width_a,
    output logic [STRIDE_W-1:0] req_stride_b,
    output logic [ELEM_W-1:0]   req_elems_b,
    output logic [ELEM_W-1:0]   req_crop_b,
    output logic [WIDTH_W-1:0]  req_width_b,
    output logic                ack_pulse,
    output logic                err_pulse
);
    state_e           state, state_d;
    kind_e            kind;
    logic             c_a2b, c_clear, c_ack, c_fast;
    logic             fire, bad_tok;
    logic [2:0]       cfg_idx;
    logic [PID_W-1:0] pid_q;
    logic [CH_W-1:0]  ch_q;
    logic             wr_en;
    field_e           wr_field;
    chan_cfg_t        rd_cfg;

    dmatok_cmd_classify u_cls (
        .cmd_id  (tok_data[CMD_W-1:0]),
        .kind    (kind),
        .a2b     (c_a2b),
        .clear   (c_clear),
        .ack_req (c_ack),
        .fast    (c_fast)
    );

    dmatok_cfg_regs #(.N_CH(N_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (ch_q),
        .wr_field (wr_field),
        .wr_data  (tok_data),
        .rd_ch    (ch_q),
        .rd_cfg   (rd_cfg)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE: if (fire) begin
                case (kind)
                    K_FULL_CFG: state_d = S_CFG;
                    K_PARAM:    state_d = S_PARAM;
                    K_ARM:      state_d = S_XCMD;
                    default:    state_d = S_IDLE;
                endcase
            end
            S_CFG:   if (fire && cfg_idx == 3'(CFG_WORDS - 1)) state_d = S_IDLE;
            S_PARAM: if (fire) state_d = S_IDLE;
            S_XCMD:  if (fire) state_d = (kind == K_XFER) ? S_DST : S_IDLE;
            S_DST:   if (fire) state_d = S_SRC;
            S_SRC:   if (fire) state_d = S_DVAR;
            S_DVAR:  if (fire) state_d = req_clear ? S_ISSUE : S_SVAR;
            S_SVAR:  if (fire) state_d = S_ISSUE;
            S_ISSUE: if (req_ready) state_d = S_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        tok_ready = (state != S_ISSUE);
        req_valid = (state == S_ISSUE);
        fire      = tok_valid && tok_ready;
        ack_pulse = req_valid && req_ready && req_ack_needed;
        wr_en     = fire && ((state == S_CFG) ||
                             (state == S_PARAM && !pid_q[PID_W-1]));
        wr_field  = (state == S_CFG) ? seq_field(cfg_idx) : field_e'(pid_q[2:0]);
        bad_tok   = fire && (
            (state == S_IDLE && (kind == K_BAD || kind == K_XFER ||
                                 (kind == K_PARAM && tok_data[PID_LSB + PID_W - 1]))) ||
            (state == S_XCMD && kind != K_XFER));
    end

    // Datapath capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_idx         <= '0;
            pid_q           <= '0;
            ch_q            <= '0;
            err_pulse       <= 1'b0;
            req_a2b         <= 1'b0;
            req_clear       <= 1'b0;
            req_ack_needed  <= 1'b0;
            req_fast        <= 1'b0;
            req_fast_height <= '0;
            req_fast_w_hi   <= '0;
            req_fast_w_lo   <= '0;
            req_dst_addr    <= '0;
            req_src_word    <= '0;
            req_dst_var     <= '0;
            req_src_var     <= '0;
        end else begin
            err_pulse <= bad_tok;
            if (fire) begin
                unique case (state)
                    S_IDLE: begin
                        ch_q    <= tok_data[CH_LSB +: CH_W];
                        pid_q   <= tok_data[PID_LSB +: PID_W];
                        cfg_idx <= '0;
                    end
                    S_CFG: cfg_idx <= cfg_idx + 3'd1;
                    S_XCMD: begin
                        ch_q            <= tok_data[CH_LSB +: CH_W];
                        req_a2b         <= c_a2b;
                        req_clear       <= c_clear;
                        req_ack_needed  <= c_ack;
                        req_fast        <= c_fast;
                        req_fast_height <= tok_data[FH_LSB +: FH_W];
                        req_fast_w_hi   <= tok_data[FWH_LSB +: FWH_W];
                        req_fast_w_lo   <= tok_data[FWL_LSB +: FWL_W];
                        req_src_var     <= '0;
                    end
                    S_DST:  req_dst_addr <= tok_data;
                    S_SRC:  req_src_word <= tok_data;
                    S_DVAR: req_dst_var  <= tok_data;
                    S_SVAR: req_src_var  <= tok_data;
                    default: ;
                endcase
            end
        end
    end

    assign req_channel  = ch_q;
    assign req_conn     = rd_cfg.conn;
    assign req_sign_ext = rd_cfg.sext;
    assign req_height   = rd_cfg.height;
    assign req_stride_a = rd_cfg.stride_a;
    assign req_elems_a  = rd_cfg.elems_a;
    assign req_crop_a   = rd_cfg.crop_a;
    assign req_width_a  = rd_cfg.width_a;
    assign req_stride_b = rd_cfg.stride_b;
    assign req_elems_b  = rd_cfg.elems_b;
    assign req_crop_b   = rd_cfg.crop_b;
    assign req_width_b  = rd_cfg.width_b;
endmodule

// File: rtl/dmatok_chk.sv
module dmatok_chk #(
    parameter int CH_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tok_valid,
    input logic            tok_ready,
    input logic            req_valid,
    input logic            req_ready,
    input logic [CH_W-1:0] req_channel,
    input logic [31:0]     req_dst_addr,
    input logic [31:0]     req_src_word,
    input logic [31:0]     req_src_var,
    input logic            req_clear,
    input logic            ack_pulse,
    input logic            err_pulse
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_channel) &&
                                    $stable(req_dst_addr) && $stable(req_src_word));

    // R5
    issue_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(tok_valid && tok_ready));

    // R6
    clear_no_srcvar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_clear |-> req_src_var == 32'd0);

    // R10
    ack_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> !req_valid);

    // R11
    err_on_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(tok_valid && tok_ready));
endmodule

bind dma_token_decoder dmatok_chk #(.CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_valid    (tok_valid),
    .tok_ready    (tok_ready),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_channel  (req_channel),
    .req_dst_addr (req_dst_addr),
    .req_src_word (req_src_word),
    .req_src_var  (req_src_var),
    .req_clear    (req_clear),
    .ack_pulse    (ack_pulse),
    .err_pulse    (err_pulse)
);

// File: tb/dma_token_decoder_tb_top.sv
module dma_token_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [31:0] tok_data = '0;
    logic        tok_ready;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [4:0]  req_channel;
    logic        req_a2b, req_clear, req_ack_needed, req_fast;
    logic [5:0]  req_fast_height;
    logic [7:0]  req_fast_w_hi;
    logic [6:0]  req_fast_w_lo;
    logic [31:0] req_dst_addr, req_src_word, req_dst_var, req_src_var;
    logic [1:0]  req_conn;
    logic        req_sign_ext;
    logic [7:0]  req_height, req_elems_a, req_crop_a, req_elems_b, req_crop_b;
    logic [31:0] req_stride_a, req_stride_b;
    logic [15:0] req_width_a, req_width_b;
    logic        ack_pulse, err_pulse;

    int n_chk = 0;
    int n_err = 0;

    // Expected configuration per channel
    logic [1:0]  m_conn [32];
    logic        m_sext [32];
    logic [7:0]  m_h    [32];
    logic [31:0] m_sa   [32];
    logic [7:0]  m_ea   [32];
    logic [7:0]  m_ca   [32];
    logic [15:0] m_wa   [32];
    logic [31:0] m_sb   [32];
    logic [7:0]  m_eb   [32];
    logic [7:0]  m_cb   [32];
    logic [15:0] m_wb   [32];

    always #5 clk = ~clk;

    dma_token_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_data(tok_data),
        .tok_ready(tok_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_channel(req_channel), .req_a2b(req_a2b), .req_clear(req_clear),
        .req_ack_needed(req_ack_needed), .req_fast(req_fast),
        .req_fast_height(req_fast_height), .req_fast_w_hi(req_fast_w_hi),
        .req_fast_w_lo(req_fast_w_lo), .req_dst_addr(req_dst_addr),
        .req_src_word(req_src_word), .req_dst_var(req_dst_var),
        .req_src_var(req_src_var), .req_conn(req_conn), .req_sign_ext(req_sign_ext),
        .req_height(req_height), .req_stride_a(req_stride_a),
        .req_elems_a(req_elems_a), .req_crop_a(req_crop_a),
        .req_width_a(req_width_a), .req_stride_b(req_stride_b),
        .req_elems_b(req_elems_b), .req_crop_b(req_crop_b),
        .req_width_b(req_width_b), .ack_pulse(ack_pulse), .err_pulse(err_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Field index in parameter-id order
    function automatic void model_write(input int ch, input int f, input logic [31:0] d);
        case (f)
            0: begin m_conn[ch] = d[1:0]; m_sext[ch] = d[8]; end
            1: m_h[ch]  = d[7:0];
            2: m_sa[ch] = d;
            3: begin m_ea[ch] = d[7:0]; m_ca[ch] = d[15:8]; end
            4: m_wa[ch] = d[15:0];
            5: m_sb[ch] = d;
            6: begin m_eb[ch] = d[7:0]; m_cb[ch] = d[15:8]; end
            default: m_wb[ch] = d[15:0];
        endcase
    endfunction

    function automatic int seq_to_field(input int i);
        case (i)
            0: return 0; 1: return 2; 2: return 3; 3: return 4;
            4: return 5; 5: return 6; 6: return 7; default: return 1;
        endcase
    endfunction

    // Starts and ends on a falling edge; the handshake edge lies in between
    task automatic send(input logic [31:0] d);
        tok_valid = 1'b1;
        tok_data  = d;
        while (!tok_ready) @(negedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic do_full_cfg(input int ch);
        send({$urandom_range(0, 2**21 - 1), 5'(ch), 6'h20});
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w = $urandom;
            send(w);
            model_write(ch, seq_to_field(i), w);
        end
        chk("R2 no err", {31'd0, err_pulse}, 0);
    endtask

    task automatic do_param(input int ch, input int pid, input logic [31:0] val);
        logic [5:0] id = 6'h21 | 6'($urandom_range(0, 15) << 1);
        send({17'($urandom), 4'(pid), 5'(ch), id});
        if (pid >= 8) chk("R4 err on high param id", {31'd0, err_pulse}, 1);
        else          chk("R3 no err", {31'd0, err_pulse}, 0);
        send(val);
        if (pid < 8) model_write(ch, pid, val);
    endtask

    task automatic do_xfer(input int ch, input logic [4:0] cmd, input int stall);
        logic [31:0] tk  = {21'($urandom), 5'(ch), 1'b0, cmd};
        logic [31:0] dst = $urandom, src = $urandom, dv = $urandom, sv = $urandom;
        logic exp_ack = !(cmd[4] || cmd[1]);
        send({26'($urandom), 6'h22});
        send(tk);
        chk("R5 no err on command", {31'd0, err_pulse}, 0);
        send(dst);
        send(src);
        send(dv);
        if (!cmd[3]) send(sv);
        chk("R5 req_valid", {31'd0, req_valid}, 1);
        chk("R5 channel", {27'd0, req_channel}, ch);
        chk("R5 dst", req_dst_addr, dst);
        chk("R5 src", req_src_word, src);
        chk("R5 dvar", req_dst_var, dv);
        chk("R6 svar", req_src_var, cmd[3] ? 32'd0 : sv);
        chk("R7 a2b", {31'd0, req_a2b}, cmd[2]);
        chk("R7 clear", {31'd0, req_clear}, cmd[3]);
        chk("R7 ack flag", {31'd0, req_ack_needed}, exp_ack);
        chk("R8 fast", {31'd0, req_fast}, cmd[0]);
        chk("R8 fast height", {26'd0, req_fast_height}, tk[31:26]);
        chk("R8 fast w hi", {24'd0, req_fast_w_hi}, tk[25:18]);
        chk("R8 fast w lo", {25'd0, req_fast_w_lo}, tk[17:11]);
        chk("R2/R3 conn", {30'd0, req_conn}, m_conn[ch]);
        chk("R2/R3 sext", {31'd0, req_sign_ext}, m_sext[ch]);
        chk("R2/R3 height", {24'd0, req_height}, m_h[ch]);
        chk("R2/R3 stride a", req_stride_a, m_sa[ch]);
        chk("R2/R3 elems a", {24'd0, req_elems_a}, m_ea[ch]);
        chk("R2/R3 crop a", {24'd0, req_crop_a}, m_ca[ch]);
        chk("R2/R3 width a", {16'd0, req_width_a}, m_wa[ch]);
        chk("R2/R3 stride b", req_stride_b, m_sb[ch]);
        chk("R2/R3 elems b", {24'd0, req_elems_b}, m_eb[ch]);
        chk("R2/R3 crop b", {24'd0, req_crop_b}, m_cb[ch]);
        chk("R2/R3 width b", {16'd0, req_width_b}, m_wb[ch]);
        for (int s = 0; s < stall; s++) begin
            chk("R9 ready low in stall", {31'd0, tok_ready}, 0);
            chk("R10 no ack while stalled", {31'd0, ack_pulse}, 0);
            @(negedge clk);
            chk("R9 valid held", {31'd0, req_valid}, 1);
            chk("R9 dst held", req_dst_addr, dst);
        end
        req_ready = 1'b1;
        #1;
        chk("R10 ack on accept", {31'd0, ack_pulse}, exp_ack);
        @(negedge clk);
        req_ready = 1'b0;
        chk("R10 request gone", {31'd0, req_valid}, 0);
        chk("R10 ack one cycle", {31'd0, ack_pulse}, 0);
        chk("R9 ready back", {31'd0, tok_ready}, 1);
    endtask

    task automatic bad_token(input logic [31:0] d, input string tag);
        send(d);
        chk(tag, {31'd0, err_pulse}, 1);
        @(negedge clk);
        chk("R11 err one cycle", {31'd0, err_pulse}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int c = 0; c < 32; c++) begin
            m_conn[c] = '0; m_sext[c] = '0; m_h[c] = '0; m_sa[c] = '0;
            m_ea[c] = '0; m_ca[c] = '0; m_wa[c] = '0; m_sb[c] = '0;
            m_eb[c] = '0; m_cb[c] = '0; m_wb[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 tok_ready", {31'd0, tok_ready}, 1);
        chk("R1 req_valid", {31'd0, req_valid}, 0);
        chk("R1 ack_pulse", {31'd0, ack_pulse}, 0);
        chk("R1 err_pulse", {31'd0, err_pulse}, 0);
        @(negedge clk);

        // R1: zero configuration seen through a transfer
        do_xfer(5, 5'h00, 0);
        // R2 directed
        do_full_cfg(0);
        do_xfer(0, 5'h04, 2);
        // R3: single field on channel 31, neighbour untouched
        do_full_cfg(31);
        do_param(31, 7, 32'hABCD_1234);
        do_param(31, 0, 32'h0000_0103);
        do_xfer(31, 5'h0C, 1);
        do_xfer(0, 5'h01, 0);
        // R4: high parameter id ignored
        do_param(31, 9, 32'hFFFF_FFFF);
        do_param(31, 15, 32'h1234_5678);
        do_xfer(31, 5'h1F, 0);
        // R11: dropped tokens
        bad_token({26'd0, 6'h24}, "R11 unknown config id");
        bad_token({26'd0, 6'h3E}, "R11 unknown config id");
        bad_token({21'd0, 5'd3, 6'h04}, "R11 transfer without arm");
        send({26'd0, 6'h22});
        bad_token({21'd0, 5'd3, 6'h20}, "R11 config id in command slot");
        do_xfer(3, 5'h12, 0);

        // Constrained random mix
        for (int n = 0; n < 250; n++) begin
            int op = $urandom_range(0, 9);
            int ch = $urandom_range(0, 31);
            if (op < 2)      do_full_cfg(ch);
            else if (op < 5) do_param(ch, $urandom_range(0, 15), $urandom);
            else             do_xfer(ch, 5'($urandom), $urandom_range(0, 3));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule